// File: doc/BRIEF.md
# Addressed SPI Slave on a Shared Chip-Select

This block is an SPI slave for a bus on which several slaves share one chip-select line. The first byte of each frame is an address. Only the slave whose configured address matches it takes part in the rest of the frame. The second byte is a command, which goes to the system-clock side with a one-cycle strobe. The third byte is a don't-care gap that gives the reply logic time to write its answer into a small transmit FIFO. From the fourth byte on, the addressed slave drives MISO with FIFO entries.

SCLK, chip-select and MOSI are brought into the system clock domain through a synchroniser and then oversampled. The whole block therefore runs on the system clock. The slave uses SPI mode 0: MOSI is sampled on the SCLK rising edge, MISO changes after the falling edge, and bytes go MSB first. MISO is driven only when the pad enable `miso_oe_o` is high. A slave that is not addressed keeps the enable low for the whole frame, and no FIFO entry is used until the slave starts to reply.

The frame controller has six states:
- `ST_IDLE`: chip-select is high.
- `ST_ADDR`: the address byte is being received.
- `ST_CMD`: the command byte is being received.
- `ST_GAP`: the don't-care delay byte.
- `ST_REPLY`: the slave is driving reply bytes.
- `ST_SKIP`: the frame is for another slave and is ignored.

Its transitions are:
- IDLE→ADDR when chip-select goes low.
- ADDR→CMD when the address matches.
- ADDR→SKIP when it does not.
- CMD→GAP when the command byte completes, with the strobe.
- GAP→REPLY when the gap byte completes.
- Any state→IDLE as soon as chip-select is high.

Top module: `aspi_slave`

## Requirements
- R1: Bits are taken MSB first on SCLK rising edges. For an addressed frame, the second byte appears on `cmd_data_o` with `cmd_valid_o` high for exactly one clock, once per frame.
- R2: The first byte after chip-select falls is compared with `own_addr_i`, and only exact equality addresses the slave.
- R3: After an address mismatch, `miso_oe_o` stays low and `cmd_valid_o` does not pulse for the rest of the frame. No FIFO entry is consumed before chip-select rises.
- R4: In an addressed frame, `miso_oe_o` is low during bytes 1, 2 and 3 (address, command, gap).
- R5: From byte 4 on, an addressed slave drives MISO MSB first with FIFO entries in write order, each bit valid before the SCLK rising edge. An entry is consumed at the first rising edge of the byte that carries it.
- R6: No FIFO entry is consumed during bytes 1 to 3. A full FIFO stays full through them.
- R7: If the FIFO is empty when a reply byte starts, the byte sent is 0xFF. `underflow_o` then goes high and stays high until reset.
- R8: If chip-select rises partway through a byte, the partial byte is dropped. The next frame decodes from its first bit.
- R9: When chip-select rises, `miso_oe_o` goes low and any FIFO entries not yet sent are discarded.
- R10: After reset, `miso_oe_o`, `full_o`, `cmd_valid_o` and `underflow_o` are low.
- R11: The FIFO holds `FIFO_DEPTH` entries (default 4). `full_o` is high when it holds that many, and writes while full are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 8 | Address this slave answers to |
| sclk_i | input | 1 | SPI clock from the master, idle low |
| cs_ni | input | 1 | Shared chip-select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial reply data, meaningful while enabled |
| miso_oe_o | output | 1 | MISO pad drive enable; low means high-impedance |
| wr_en_i | input | 1 | Transmit FIFO write strobe |
| wr_data_i | input | 8 | Transmit FIFO write data |
| full_o | output | 1 | Transmit FIFO full |
| cmd_valid_o | output | 1 | One-cycle strobe: command byte received |
| cmd_data_o | output | 8 | Received command byte |
| underflow_o | output | 1 | Sticky flag: a reply byte found the FIFO empty |

## Verification
The hardest case to reach from the ports is the claim that nothing leaves the FIFO before byte 4. The FIFO level is only visible through `full_o`, and it is flushed when chip-select rises. The stimulus therefore fills the FIFO, holds chip-select low after the third byte, checks `full_o` there, and only then continues or ends the frame. It does the same inside a frame addressed to another slave. A second hard case is a reply byte whose FIFO entry was prepared but never clocked out: a frame is stopped right after the gap byte, and the next frame must find an empty FIFO.

// File: rtl/aspi_pkg.sv
package aspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_GAP,
        ST_REPLY,
        ST_SKIP
    } frame_state_e;

endpackage

// File: rtl/aspi_sync.sv
module aspi_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RESET_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/aspi_tx_fifo.sv
module aspi_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAPACITY  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;

    assign full_o  = (count_q == CAPACITY);
    assign empty_o = (count_q == '0);
    assign push_ok = push_i && !full_o && !flush_i;
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign head_o  = slots[rd_ptr_q];

    always_ff @(posedge clk_i) begin
        if (push_ok) begin
            slots[wr_ptr_q] <= data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // A pop request must always find data: the reply path only asks for
    // entries it saw present when the byte was prepared (R5).
    assert_pop_has_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);

    // The occupancy never exceeds the configured depth (R11).
    assert_count_bounded_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= CAPACITY);

    // A full FIFO that gets a write but no read or flush stays full (R11).
    assert_full_write_dropped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);

endmodule

// File: rtl/aspi_frame_ctrl.sv
module aspi_frame_ctrl
    import aspi_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_act_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] own_addr_i,
    output frame_state_e      state_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_data_o
);

    frame_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!cs_act_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ADDR;
                ST_ADDR:  if (byte_done_i) state_d = (byte_i == own_addr_i) ? ST_CMD : ST_SKIP;
                ST_CMD:   if (byte_done_i) state_d = ST_GAP;
                ST_GAP:   if (byte_done_i) state_d = ST_REPLY;
                ST_REPLY: state_d = ST_REPLY;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_valid_o <= 1'b0;
            cmd_data_o  <= '0;
        end else begin
            cmd_valid_o <= cs_act_i && byte_done_i && (state_q == ST_CMD);
            if (cs_act_i && byte_done_i && (state_q == ST_CMD)) begin
                cmd_data_o <= byte_i;
            end
        end
    end

    assign state_o = state_q;

    // The command strobe lasts a single clock (R1).
    assert_cmd_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |=> !cmd_valid_o);

    // A skipped frame stays skipped until chip-select ends it (R3).
    assert_skip_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SKIP) |=> (state_q == ST_SKIP || state_q == ST_IDLE));

    // No command strobe can follow a skipped address (R3).
    assert_skip_no_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SKIP) |=> !cmd_valid_o);

endmodule

// File: rtl/aspi_slave.sv
module aspi_slave
    import aspi_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BYTE_W-1:0] own_addr_i,
    input  logic              sclk_i,
    input  logic              cs_ni,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              full_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              underflow_o
);

    localparam int                  BIT_CNT_W = $clog2(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0]    FILL_BYTE = '1;

    // Input synchronisation: {chip-select, clock, data}; chip-select idles high.
    logic [2:0] pins_raw, pins_sync;
    logic       cs_n_s, sclk_s, mosi_s;

    assign pins_raw = {cs_ni, sclk_i, mosi_i};

    aspi_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_raw),
        .q_o    (pins_sync)
    );

    assign {cs_n_s, sclk_s, mosi_s} = pins_sync;

    // Edge detection on the synchronised pins.
    logic sclk_q, cs_n_q;
    logic cs_act, sclk_rise, sclk_fall, cs_end;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_n_q <= cs_n_s;
        end
    end

    assign cs_act    = !cs_n_s;
    assign sclk_rise = cs_act && sclk_s && !sclk_q;
    assign sclk_fall = cs_act && !sclk_s && sclk_q;
    assign cs_end    = cs_n_s && !cs_n_q;

    // Receive shifter and bit counter.
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-1:0]    rx_sr_q;
    logic [BYTE_W-1:0]    rx_byte;
    logic                 byte_done;

    assign rx_byte   = {rx_sr_q[BYTE_W-2:0], mosi_s};
    assign byte_done = sclk_rise && (bit_cnt_q == LAST_BIT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
        end else if (!cs_act) begin
            bit_cnt_q <= '0;
        end else if (sclk_rise) begin
            rx_sr_q   <= rx_byte;
            bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
        end
    end

    // Frame controller.
    frame_state_e state;

    aspi_frame_ctrl #(
        .BYTE_W (BYTE_W)
    ) u_frame_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_act_i    (cs_act),
        .byte_done_i (byte_done),
        .byte_i      (rx_byte),
        .own_addr_i  (own_addr_i),
        .state_o     (state),
        .cmd_valid_o (cmd_valid_o),
        .cmd_data_o  (cmd_data_o)
    );

    // Transmit FIFO.
    logic [BYTE_W-1:0] fifo_head;
    logic              fifo_empty, fifo_full, fifo_pop;

    aspi_tx_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (FIFO_DEPTH)
    ) u_tx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (cs_end),
        .push_i  (wr_en_i),
        .data_i  (wr_data_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    assign full_o = fifo_full;

    // Transmit path: peek the head on the falling edge that ends a byte,
    // commit the pop on the first rising edge of the byte that carries it.
    logic [BYTE_W-1:0] tx_sr_q, load_byte;
    logic              miso_q, oe_q, from_fifo_q, underflow_q, byte_start;

    assign load_byte  = fifo_empty ? FILL_BYTE : fifo_head;
    assign byte_start = sclk_rise && (bit_cnt_q == '0) && (state == ST_REPLY);
    assign fifo_pop   = byte_start && from_fifo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_sr_q     <= '0;
            miso_q      <= 1'b0;
            oe_q        <= 1'b0;
            from_fifo_q <= 1'b0;
        end else if (!cs_act) begin
            oe_q        <= 1'b0;
            from_fifo_q <= 1'b0;
        end else if (sclk_fall && (state == ST_REPLY)) begin
            if (bit_cnt_q == '0) begin
                miso_q      <= load_byte[BYTE_W-1];
                tx_sr_q     <= load_byte << 1;
                from_fifo_q <= !fifo_empty;
                oe_q        <= 1'b1;
            end else begin
                miso_q  <= tx_sr_q[BYTE_W-1];
                tx_sr_q <= tx_sr_q << 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            underflow_q <= 1'b0;
        end else if (byte_start && !from_fifo_q) begin
            underflow_q <= 1'b1;
        end
    end

    assign miso_o      = miso_q;
    assign miso_oe_o   = oe_q;
    assign underflow_o = underflow_q;

    // MISO drive is only ever enabled while replying (R4).
    assert_quiet_before_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state != ST_REPLY) |-> !oe_q);

    // Outside the reply phase a full FIFO is never drained (R6).
    assert_fifo_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_act && state != ST_REPLY && fifo_full) |=> fifo_full);

    // The underflow flag never clears once set (R7).
    assert_underflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_q |=> underflow_q);

    // Deselect always releases the pad next cycle (R9).
    assert_release_on_deselect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_act |=> !oe_q);

endmodule

// File: tb/test_aspi_slave.sv
module test_aspi_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       full, cmd_valid, underflow;
    logic [7:0] cmd_data;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic [7:0] last_cmd = 8'h00;

    always #10 clk = ~clk;

    aspi_slave i_aspi_slave (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .own_addr_i  (own_addr),
        .sclk_i      (sclk),
        .cs_ni       (cs_n),
        .mosi_i      (mosi),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .full_o      (full),
        .cmd_valid_o (cmd_valid),
        .cmd_data_o  (cmd_data),
        .underflow_o (underflow)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes  = strobes + 1;
            last_cmd = cmd_data;
        end
    end

    // Fields: own address, frame address, command, entries to write, entry 0, entry 1.
    localparam logic [47:0] VEC [6] = '{
        {8'h5A, 8'h5A, 8'h3C, 8'd2, 8'hA5, 8'hC3},
        {8'h5A, 8'h11, 8'h3C, 8'd2, 8'hA5, 8'hC3},
        {8'h81, 8'h81, 8'h00, 8'd1, 8'h7E, 8'h00},
        {8'hFF, 8'hFF, 8'hFF, 8'd0, 8'h00, 8'h00},
        {8'h00, 8'h80, 8'h12, 8'd2, 8'h33, 8'h44},
        {8'h01, 8'h01, 8'h96, 8'd2, 8'h00, 8'hFF}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic oe, output logic v);
        mosi = b;
        repeat (8) @(negedge clk);
        oe = miso_oe;
        v  = miso;
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic [7:0] rx, output int drv);
        logic oe, v;
        drv = 0;
        rx  = 8'h00;
        for (int b = 7; b >= 0; b--) begin
            send_bit(d[b], oe, v);
            rx[b] = v;
            if (oe) drv++;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx [8];
        int         drv [8];
        logic [7:0] scratch;
        int         s0;
        bit         exp_uf;

        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: state right after reset
        check(miso_oe == 1'b0, "R10 oe after reset", 32'(miso_oe), 0);
        check(full == 1'b0, "R10 full after reset", 32'(full), 0);
        check(cmd_valid == 1'b0, "R10 strobe after reset", 32'(cmd_valid), 0);
        check(underflow == 1'b0, "R10 underflow after reset", 32'(underflow), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1, R2, R3, R4, R5, R7
        exp_uf = 1'b0;
        for (int v = 0; v < 6; v++) begin
            logic [7:0] own, adr, cmd, d0, d1, expb;
            int         np;
            bit         hit;
            own = VEC[v][47:40];
            adr = VEC[v][39:32];
            cmd = VEC[v][31:24];
            np  = int'(VEC[v][23:16]);
            d0  = VEC[v][15:8];
            d1  = VEC[v][7:0];
            hit = (own == adr);
            own_addr = own;
            for (int k = 0; k < np; k++) push(k == 0 ? d0 : d1);
            s0 = strobes;
            cs_low();
            send_byte(adr, rx[0], drv[0]);
            send_byte(cmd, rx[1], drv[1]);
            for (int k = 2; k < 5; k++) send_byte(8'h00, rx[k], drv[k]);
            cs_high();
            if (hit) begin
                check(strobes - s0 == 1, "R2 matching address gives one strobe", 32'(strobes - s0), 1);
                check(last_cmd == cmd, "R1 command byte value", 32'(last_cmd), 32'(cmd));
                for (int k = 0; k < 3; k++)
                    check(drv[k] == 0, "R4 no drive in bytes 1-3", 32'(drv[k]), 0);
                for (int k = 0; k < 2; k++) begin
                    expb = (k < np) ? ((k == 0) ? d0 : d1) : 8'hFF;
                    if (k >= np) exp_uf = 1'b1;
                    check(drv[3+k] == 8, "R5 reply byte fully driven", 32'(drv[3+k]), 8);
                    check(rx[3+k] == expb, "R5 R7 reply byte value", 32'(rx[3+k]), 32'(expb));
                end
            end else begin
                check(strobes == s0, "R3 no strobe on mismatch", 32'(strobes - s0), 0);
                for (int k = 0; k < 5; k++)
                    check(drv[k] == 0, "R3 no drive on mismatch", 32'(drv[k]), 0);
            end
            check(underflow == exp_uf, "R7 sticky underflow", 32'(underflow), 32'(exp_uf));
        end

        // R3 and R6: a full FIFO is untouched by a skipped frame and by bytes 1-3
        do_reset();
        own_addr = 8'h42;
        for (int k = 0; k < 5; k++) push(8'h10 + 8'(k));
        check(full == 1'b1, "R11 full after depth writes", 32'(full), 1);
        cs_low();
        send_byte(8'h43, rx[0], drv[0]);
        for (int k = 1; k < 5; k++) send_byte(8'h00, rx[k], drv[k]);
        check(full == 1'b1, "R3 skipped frame keeps FIFO", 32'(full), 1);
        cs_high();
        check(full == 1'b0, "R9 deselect flushes FIFO", 32'(full), 0);
        for (int k = 0; k < 5; k++) push(8'h20 + 8'(k));
        cs_low();
        send_byte(8'h42, rx[0], drv[0]);
        send_byte(8'h5C, rx[1], drv[1]);
        send_byte(8'h00, rx[2], drv[2]);
        check(full == 1'b1, "R6 FIFO untouched through byte 3", 32'(full), 1);
        for (int k = 3; k < 8; k++) send_byte(8'h00, rx[k], drv[k]);
        for (int k = 0; k < 4; k++)
            check(rx[3+k] == 8'h20 + 8'(k), "R11 R5 entries in write order", 32'(rx[3+k]), 32'(8'h20 + 8'(k)));
        check(rx[7] == 8'hFF, "R11 write while full dropped", 32'(rx[7]), 32'hFF);
        check(underflow == 1'b1, "R7 underflow after drain", 32'(underflow), 1);
        check(miso_oe == 1'b1, "R5 drive held while selected", 32'(miso_oe), 1);
        cs_high();
        check(miso_oe == 1'b0, "R9 pad released on deselect", 32'(miso_oe), 0);

        // R9: entries left at the end of a frame are discarded
        push(8'h11);
        push(8'h22);
        cs_low();
        send_byte(8'h42, rx[0], drv[0]);
        send_byte(8'h01, rx[1], drv[1]);
        send_byte(8'h00, rx[2], drv[2]);
        cs_high();
        cs_low();
        for (int k = 0; k < 3; k++) send_byte(k == 0 ? 8'h42 : 8'h00, rx[k], drv[k]);
        send_byte(8'h00, rx[3], drv[3]);
        cs_high();
        check(rx[3] == 8'hFF, "R9 leftover entries discarded", 32'(rx[3]), 32'hFF);

        // R8: partial byte aborted by deselect
        do_reset();
        own_addr = 8'h42;
        cs_low();
        begin
            logic oe, bv;
            send_bit(1'b1, oe, bv);
            send_bit(1'b0, oe, bv);
            send_bit(1'b1, oe, bv);
        end
        cs_high();
        push(8'h5D);
        s0 = strobes;
        cs_low();
        send_byte(8'h42, rx[0], drv[0]);
        send_byte(8'h77, rx[1], drv[1]);
        send_byte(8'h00, rx[2], drv[2]);
        send_byte(8'h00, rx[3], drv[3]);
        cs_high();
        check(strobes - s0 == 1, "R8 frame after abort decoded", 32'(strobes - s0), 1);
        check(last_cmd == 8'h77, "R8 command after abort", 32'(last_cmd), 32'h77);
        check(rx[3] == 8'h5D, "R8 reply after abort", 32'(rx[3]), 32'h5D);
        check(underflow == 1'b0, "R8 no underflow after abort", 32'(underflow), 0);
        scratch = rx[3];

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule